// File: doc/BRIEF.md
# Buck Converter Cycle Gate Controller

This block decides, tick by tick, how the power switches of a synchronous step-down converter are driven within each switching period. It runs on a control clock, and a fixed number of ticks make up one switching period. Once per period it takes in a requested on-time as a tick count, along with several comparator flags: high-side current limit, feedback-low (hard short), output over-voltage, and a light-load threshold comparator. From these it produces the high-side enable, the low-side enable and a tri-state request for the switch node.

Within a period the high-side switch conducts first. The block then waits a programmable dead time and turns on the low-side switch, which it turns off again one dead time before the period ends. On top of this basic pattern the block applies several protections. It truncates the on-phase on current limit. It drops a fixed number of periods after a limit event that happens during a short. It limits the on-time on every eighth period so that the bootstrap capacitor can recharge. It tri-states the switch node for any period that opens with over-voltage. When the requested on-time is small, it moves into pulse-skipping light-load operation.

Top module: `buck_cycle_gate`

## Requirements
- R1: While enabled in normal (PWM) mode, `hs_on` is high for the first min(`duty_req`, PERIOD_TICKS*97/100) ticks of each period, counted from the tick where `period_start` is high.
- R2: In every eighth period after enable (period index 7, 15, ...), the high-side on-time is additionally limited to PERIOD_TICKS - BOOT_OFF_TICKS ticks.
- R3: If `oc_flag` is high on a tick where `hs_on` is high, `hs_on` is low from the next tick until the end of that period. The following period is unaffected.
- R4: If `fb_low` is also high when R3 truncates the on-phase, both switches stay off for the next SKIP_CYCLES whole periods, and normal switching resumes in the period after them.
- R5: `ov_flag` is sampled only at the boundary between periods. A period that starts with it high has `sw_hiz` high and both switches off for its whole length. A rise partway through a period leaves that period unchanged, and a pulse that ends before the boundary has no effect.
- R6: When `duty_req` < PFM_DUTY_LIM, `pfm_mode` is high for the period, and the period carries a pulse only if `pfm_below` was high at its start. If there is no pulse, both switches stay off. Once `duty_req` is at or above the limit, the block is back in PWM mode in the next period.
- R7: The low-side switch is on from tick (high-side end + `dead_ticks`) up to, but not including, tick PERIOD_TICKS - `dead_ticks`. `hs_on` and `ls_on` are never high together.
- R8: When `enable` is low, `hs_on` and `ls_on` are low and `sw_hiz` is high in the same tick. When `enable` rises again, the next period is period index 0.
- R9: While enabled, `period_start` is high on the first tick of every period.
- R10: In reset with `enable` low, `hs_on`, `ls_on` and `period_start` are low, and `sw_hiz` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock (one tick) |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Regulator enable; low forces tri-state |
| duty_req | input | $clog2(PERIOD_TICKS+1) | Requested high-side on-time in ticks |
| oc_flag | input | 1 | High-side current limit reached |
| fb_low | input | 1 | Feedback below short threshold |
| ov_flag | input | 1 | Output over-voltage comparator |
| pfm_below | input | 1 | Output below light-load threshold |
| dead_ticks | input | DEAD_W | Dead time in ticks |
| hs_on | output | 1 | High-side switch on |
| ls_on | output | 1 | Low-side switch on |
| sw_hiz | output | 1 | Switch node tri-state |
| pfm_mode | output | 1 | Current period runs in light-load mode |
| period_start | output | 1 | First tick of a period |

## Verification
The bench builds the block with PERIOD_TICKS=20, BOOT_OFF_TICKS=4 and PFM_DUTY_LIM=4. With these values the 97% clamp works out to 19 ticks, and the bootstrap limit of 16 ticks sits below it, so the two limits give different on-times. Because the bench measures the on-times and off-times of whole periods, each of these limits shows up as a distinct count. A period of only 20 ticks also means that the eight-period bootstrap rhythm, the four-period skip and the sampling of over-voltage at the period boundary all come up many times in a short run.

// File: rtl/buck_cycle_gate.sv
module buck_cycle_gate #(
  parameter int PERIOD_TICKS   = 100,
  parameter int BOOT_OFF_TICKS = 24,
  parameter int PFM_DUTY_LIM   = 10,
  parameter int SKIP_CYCLES    = 4,
  parameter int BOOT_EVERY     = 8,
  parameter int DEAD_W         = 4
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                enable,
  input  logic [$clog2(PERIOD_TICKS+1)-1:0]   duty_req,
  input  logic                                oc_flag,
  input  logic                                fb_low,
  input  logic                                ov_flag,
  input  logic                                pfm_below,
  input  logic [DEAD_W-1:0]                   dead_ticks,
  output logic                                hs_on,
  output logic                                ls_on,
  output logic                                sw_hiz,
  output logic                                pfm_mode,
  output logic                                period_start
);

  localparam int TW = $clog2(PERIOD_TICKS);
  localparam int DW = $clog2(PERIOD_TICKS + 1);
  localparam int SW = DW + 1;
  localparam int CW = $clog2(BOOT_EVERY);
  localparam int KW = $clog2(SKIP_CYCLES + 1);
  localparam logic [TW-1:0] LAST     = TW'(PERIOD_TICKS - 1);
  localparam logic [CW-1:0] LASTC    = CW'(BOOT_EVERY - 1);
  localparam logic [DW-1:0] DMAX     = DW'(PERIOD_TICKS * 97 / 100);
  localparam logic [DW-1:0] BOOT_MAX = DW'(PERIOD_TICKS - BOOT_OFF_TICKS);
  localparam logic [DW-1:0] PFM_LIM  = DW'(PFM_DUTY_LIM);
  localparam logic [KW-1:0] SKIP_N   = KW'(SKIP_CYCLES);

  logic [TW-1:0] tick;
  logic [CW-1:0] cyc;
  logic [KW-1:0] skip_left;
  logic [DW-1:0] on_len, cut_at;
  logic          run, ov_cyc, hs_cut;

  logic [CW-1:0] cyc_nx;
  logic [DW-1:0] duty_cl, on_nx, hs_end, tick_d;
  logic [SW-1:0] ls_lo, ls_hi, tick_s;
  logic          pfm_nx, hs_raw, ls_raw;

  assign cyc_nx  = (cyc == LASTC) ? '0 : cyc + CW'(1);
  assign duty_cl = (duty_req > DMAX) ? DMAX : duty_req;
  assign on_nx   = (cyc_nx == LASTC && duty_cl > BOOT_MAX) ? BOOT_MAX : duty_cl;
  assign pfm_nx  = duty_req < PFM_LIM;

  assign tick_d  = DW'(tick);
  assign tick_s  = SW'(tick);
  assign hs_end  = hs_cut ? cut_at : on_len;
  assign ls_lo   = SW'(hs_end) + SW'(dead_ticks);
  assign ls_hi   = SW'(PERIOD_TICKS) - SW'(dead_ticks);

  assign hs_raw  = run && !ov_cyc && !hs_cut && (tick_d < on_len);
  assign ls_raw  = run && !ov_cyc && (tick_s >= ls_lo) && (tick_s < ls_hi);

  assign hs_on        = enable && hs_raw;
  assign ls_on        = enable && ls_raw;
  assign sw_hiz       = !enable || ov_cyc;
  assign period_start = enable && (tick == '0);

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      tick      <= LAST;
      cyc       <= LASTC;
      skip_left <= '0;
      on_len    <= '0;
      cut_at    <= '0;
      run       <= 1'b0;
      ov_cyc    <= 1'b0;
      hs_cut    <= 1'b0;
      pfm_mode  <= 1'b0;
    end else if (tick == LAST) begin
      tick     <= '0;
      cyc      <= cyc_nx;
      ov_cyc   <= ov_flag;
      on_len   <= on_nx;
      pfm_mode <= pfm_nx;
      hs_cut   <= 1'b0;
      if (skip_left != '0) begin
        skip_left <= skip_left - KW'(1);
        run       <= 1'b0;
      end else begin
        run <= !pfm_nx || pfm_below;
      end
    end else begin
      tick <= tick + TW'(1);
      if (hs_raw && oc_flag) begin
        hs_cut <= 1'b1;
        cut_at <= tick_d + DW'(1);
        if (fb_low) skip_left <= SKIP_N;
      end
    end
  end

  // R7: the two switches never conduct together
  assert_no_overlap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_on && ls_on));

  // R7: with a non-zero dead time the low side stays off on the tick the high side falls
  assert_dead_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(hs_on) && dead_ticks != '0) |-> !ls_on);

  // R1: high side never on at or beyond the duty clamp
  assert_duty_clamp_R1: assert property (@(posedge clk) disable iff (!rst_n)
    hs_on |-> (tick_d < DMAX));

  // R2: bootstrap period keeps its forced off-time
  assert_boot_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_on && cyc == LASTC) |-> (tick_d < BOOT_MAX));

  // R3: current limit ends the on-phase on the next tick
  assert_oc_cut_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_on && oc_flag && tick != LAST) |=> !hs_on);

  // R5: a period that opens with over-voltage is tri-stated
  assert_ov_hiz_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable) && $past(rst_n) && tick == '0 && $past(ov_flag)) |-> (sw_hiz && !hs_on));

  // R6: light-load period without a below-threshold request carries no pulse
  assert_pfm_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable) && $past(rst_n) && tick == '0 && pfm_mode && !$past(pfm_below)) |-> (!hs_on && !ls_on));

endmodule

// File: tb/tb_buck_cycle_gate.sv
module tb_buck_cycle_gate;
  localparam int CLK_PER = 10;
  localparam int P       = 20;
  localparam int DW      = $clog2(P + 1);

  logic clk = 1'b0;
  logic rst_n, enable, oc_flag, fb_low, ov_flag, pfm_below;
  logic [DW-1:0] duty_req;
  logic [3:0] dead_ticks;
  logic hs_on, ls_on, sw_hiz, pfm_mode, period_start;

  int checks = 0;
  int fails  = 0;
  int ci     = 0;

  buck_cycle_gate #(.PERIOD_TICKS(P), .BOOT_OFF_TICKS(4), .PFM_DUTY_LIM(4),
                    .SKIP_CYCLES(4), .BOOT_EVERY(8), .DEAD_W(4)) dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .duty_req(duty_req),
    .oc_flag(oc_flag), .fb_low(fb_low), .ov_flag(ov_flag), .pfm_below(pfm_below),
    .dead_ticks(dead_ticks), .hs_on(hs_on), .ls_on(ls_on), .sw_hiz(sw_hiz),
    .pfm_mode(pfm_mode), .period_start(period_start));

  always #(CLK_PER/2) clk = ~clk;

  // duty, pfm_below, expected hs ticks (before bootstrap limit), expected ls ticks, expected pfm_mode
  localparam int NV = 8;
  localparam int VEC [NV][5] = '{
    '{12, 1, 12,  4, 0},
    '{ 0, 1,  0, 16, 1},
    '{25, 1, 19,  0, 0},
    '{19, 1, 19,  0, 0},
    '{ 3, 1,  3, 13, 1},
    '{ 3, 0,  0,  0, 1},
    '{ 4, 0,  4, 12, 0},
    '{31, 1, 19,  0, 0}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Called at the negedge of tick 0; returns at the negedge of the next tick 0.
  task automatic run_cycle(input int oc_t, input int ov_on_t, input int ov_off_t,
                           output int nh, output int nl, output int nz, output int nov);
    nh = 0; nl = 0; nz = 0; nov = 0;
    chk("R9 period_start", int'(period_start), 1);
    for (int t = 0; t < P; t++) begin
      oc_flag = (t == oc_t);
      if (t == ov_on_t)  ov_flag = 1'b1;
      if (t == ov_off_t) ov_flag = 1'b0;
      if (hs_on) nh++;
      if (ls_on) nl++;
      if (sw_hiz) nz++;
      if (hs_on && ls_on) nov++;
      @(negedge clk);
    end
    oc_flag = 1'b0;
    ci++;
  endtask

  int h, l, z, o, eh;

  initial begin
    #(CLK_PER * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; enable = 1'b0; oc_flag = 1'b0; fb_low = 1'b0; ov_flag = 1'b0;
    pfm_below = 1'b1; duty_req = 12; dead_ticks = 4'd2;
    repeat (3) @(negedge clk);
    chk("R10 hs_on", int'(hs_on), 0);
    chk("R10 ls_on", int'(ls_on), 0);
    chk("R10 sw_hiz", int'(sw_hiz), 1);
    chk("R10 period_start", int'(period_start), 0);
    rst_n = 1'b1;
    @(negedge clk);
    enable = 1'b1;
    @(negedge clk);
    ci = 0;

    // Vector walk: R1 R2 R6 R7
    for (int v = 0; v < NV; v++) begin
      duty_req  = DW'(VEC[v][0]);
      pfm_below = VEC[v][1][0];
      run_cycle(-1, -1, -1, h, l, z, o);
      eh = VEC[v][2];
      if ((ci % 8) == 7 && eh > 16) eh = 16;
      chk("R6 pfm_mode", int'(pfm_mode), VEC[v][4]);
      run_cycle(-1, -1, -1, h, l, z, o);
      chk("R1/R2 hs ticks", h, eh);
      chk("R7 ls ticks", l, VEC[v][3]);
      chk("R7 overlap", o, 0);
    end

    // R7 wider dead time
    duty_req = 10; pfm_below = 1'b1; dead_ticks = 4'd3;
    run_cycle(-1, -1, -1, h, l, z, o);
    run_cycle(-1, -1, -1, h, l, z, o);
    chk("R7 hs dead3", h, 10);
    chk("R7 ls dead3", l, 4);
    dead_ticks = 4'd2;
    run_cycle(-1, -1, -1, h, l, z, o);

    // R3 truncation without short
    run_cycle(5, -1, -1, h, l, z, o);
    chk("R3 hs truncated", h, 6);
    chk("R3 ls after cut", l, 10);
    run_cycle(-1, -1, -1, h, l, z, o);
    chk("R3 next period normal", h, 10);

    // R4 truncation during short
    fb_low = 1'b1;
    run_cycle(4, -1, -1, h, l, z, o);
    fb_low = 1'b0;
    chk("R4 hs truncated", h, 5);
    chk("R4 ls after cut", l, 11);
    for (int k = 0; k < 4; k++) begin
      run_cycle(-1, -1, -1, h, l, z, o);
      chk("R4 skipped hs", h, 0);
      chk("R4 skipped ls", l, 0);
    end
    run_cycle(-1, -1, -1, h, l, z, o);
    chk("R4 resume hs", h, 10);

    // R5 mid-period rise: finish this period, tri-state the next
    run_cycle(-1, 6, -1, h, l, z, o);
    chk("R5 mid-period hs", h, 10);
    chk("R5 mid-period hiz", z, 0);
    run_cycle(-1, -1, 0, h, l, z, o);
    chk("R5 hiz period", z, P);
    chk("R5 hiz hs", h, 0);
    chk("R5 hiz ls", l, 0);
    run_cycle(-1, 5, 8, h, l, z, o);
    chk("R5 recovered hs", h, 10);
    run_cycle(-1, -1, -1, h, l, z, o);
    chk("R5 short pulse ignored hiz", z, 0);
    chk("R5 short pulse ignored hs", h, 10);

    // R8 disable mid-period, then restart at period index 0
    duty_req = 19;
    repeat (3) @(negedge clk);
    enable = 1'b0;
    #1;
    chk("R8 hs off", int'(hs_on), 0);
    chk("R8 ls off", int'(ls_on), 0);
    chk("R8 hiz", int'(sw_hiz), 1);
    @(negedge clk);
    enable = 1'b1;
    @(negedge clk);
    ci = 0;
    for (int k = 0; k < 7; k++) run_cycle(-1, -1, -1, h, l, z, o);
    chk("R8 index0 clamp hs", h, 19);
    run_cycle(-1, -1, -1, h, l, z, o);
    chk("R8/R2 eighth period hs", h, 16);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule